// File: doc/BRIEF.md
# Time-Based Link Analysis Counter

This block measures link behaviour over a time window. Software picks a report and a window length through a 32-bit control word, then sets the enable bit. The report is either the number of cycles the link spends in a chosen power or training state, or the transmitted or received payload volume in 16-byte chunks. The window is one of several fixed lengths from 4 µs to 4 s, timed from a cycles-per-microsecond parameter. There is also a manual mode, in which the block counts for as long as software leaves it enabled.

The result is 64 bits wide and is read as two 32-bit words. A read of the upper word captures the lower word at the same moment, so a later read of the lower word belongs to the same value. The link-state inputs arrive as one-hot flags, and the payload inputs arrive as per-cycle chunk counts. The block does not track the link's own state machine or decode any packet framing.

Top module: `link_window_meter`

## Requirements
- R1: After reset, the control word, the upper result word and the lower result word all read 0.
- R2: Register addresses are: control at 0x10, lower result word at 0x14, upper result word at 0x18. Control bits 31:24 hold the report code, bits 15:8 hold the duration code, bit 1 reads the done flag, and bit 0 is the enable. A read of any other address returns 0.
- R3: Duration code 0xFF gives a window of 4 µs. Codes 0x01 to 0x06 give 1 ms, 10 ms, 100 ms, 1 s, 2 s and 4 s. Each window lasts exactly that many microseconds times CYCLES_PER_US clock cycles, so report code 0x00 ends with the window length as its result.
- R4: When a timed window ends, the result freezes, enable reads 0 and done reads 1. The next start clears done.
- R5: A start clears the result. A start is a control write with bit 0 set while the block is idle.
- R6: Report codes count cycles in which the selected link-state flag is high. The flag bits are: bit 0 L0, bit 1 TX L0s, bit 2 RX L0s, bit 3 L1, bit 4 L1.1, bit 5 L1.2, bit 6 configuration/recovery, bit 7 L1 auxiliary. Code 0x00 counts every cycle. Codes 0x01 to 0x07 select TX L0s, RX L0s, L0, L1, L1.1, L1.2 and configuration/recovery. Code 0x08 needs both bit 1 and bit 2. Code 0x09 selects L1 auxiliary.
- R7: Report code 0x20 adds the TX chunk count each cycle, and code 0x21 adds the RX chunk count.
- R8: Duration code 0x00 and any unlisted duration code mean manual mode. The result accumulates on every cycle up to and including the cycle of the stop write, then holds. Done stays 0.
- R9: While the block is enabled, a control write with bit 0 set has no effect. A write with bit 0 clear stops the block but leaves the report and duration fields unchanged.
- R10: A read of the upper word captures the lower word at that cycle. Reads of the lower word return this captured value.
- R11: A stop write during a timed window ends it early. The result holds and done stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe (captures on upper-word read) |
| regAddr | input | 8 | Register byte address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, combinational from regAddr |
| linkState | input | 8 | One-hot link-state flags |
| txChunks | input | CHUNK_W | TX payload chunks this cycle |
| rxChunks | input | CHUNK_W | RX payload chunks this cycle |

## Verification
The hardest cases to reach from the ports are the exact end of a window and the snapshot taken at the upper-word read. Both depend on the edge at which a write or read lands relative to the counting. The bench sets CYCLES_PER_US to 2, so the 4 µs and 1 ms windows last 8 and 2000 cycles. It issues register accesses at fixed two-cycle spacing, so the expected count of every manual or aborted run follows directly from the number of idle cycles between accesses. An attempt to reconfigure the block while it runs is checked through the control readback and through the final count.

// File: rtl/lwm_pkg.sv
package lwm_pkg;
  localparam logic [7:0] ADDR_CTRL = 8'h10;
  localparam logic [7:0] ADDR_LOW  = 8'h14;
  localparam logic [7:0] ADDR_HIGH = 8'h18;

  localparam int ST_L0 = 0, ST_TXL0S = 1, ST_RXL0S = 2, ST_L1 = 3;
  localparam int ST_L11 = 4, ST_L12 = 5, ST_CFG = 6, ST_AUX = 7;

  typedef struct packed {
    logic clearAcc;
    logic accumulate;
    logic snapLow;
  } lwmCmd_t;

  // Window length in microseconds; 0 means manual mode
  function automatic logic [31:0] durMicros(input logic [7:0] code);
    case (code)
      8'h01:   return 32'd1000;
      8'h02:   return 32'd10000;
      8'h03:   return 32'd100000;
      8'h04:   return 32'd1000000;
      8'h05:   return 32'd2000000;
      8'h06:   return 32'd4000000;
      8'hFF:   return 32'd4;
      default: return 32'd0;
    endcase
  endfunction
endpackage

// File: rtl/lwm_ctrl.sv
module lwm_ctrl
  import lwm_pkg::*;
#(
  parameter int CYCLES_PER_US = 125,
  parameter int TIMER_W = 40
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          regWrEn,
  input  logic          regRdEn,
  input  logic [7:0]    regAddr,
  input  logic [31:0]   regWrData,
  output lwmCmd_t       cmd,
  output logic [31:0]   ctrlWord,
  output logic [7:0]    activeSel,
  output logic          running,
  output logic          done
);
  logic [7:0]         selQ, durQ;
  logic               runQ, doneQ;
  logic [TIMER_W-1:0] timerQ, target;
  logic [31:0]        windowUs;
  logic               wrCtrl, startReq, stopReq, timed, lastTick;
  logic               unusedWrBits;

  assign unusedWrBits = ^{regWrData[23:16], regWrData[7:1]};

  assign wrCtrl   = regWrEn && (regAddr == ADDR_CTRL);
  assign startReq = wrCtrl && regWrData[0] && !runQ;
  assign stopReq  = wrCtrl && !regWrData[0] && runQ;
  assign windowUs = durMicros(durQ);
  assign timed    = (windowUs != 32'd0);
  assign target   = TIMER_W'(windowUs) * TIMER_W'(CYCLES_PER_US);
  assign lastTick = runQ && timed && (timerQ == target - TIMER_W'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      selQ   <= '0;
      durQ   <= '0;
      runQ   <= 1'b0;
      doneQ  <= 1'b0;
      timerQ <= '0;
    end else begin
      if (wrCtrl && !runQ) begin
        selQ <= regWrData[31:24];
        durQ <= regWrData[15:8];
      end
      if (startReq) begin
        runQ   <= 1'b1;
        doneQ  <= 1'b0;
        timerQ <= '0;
      end else if (stopReq) begin
        runQ <= 1'b0;
      end else if (runQ) begin
        timerQ <= timerQ + TIMER_W'(1);
        if (lastTick) begin
          runQ  <= 1'b0;
          doneQ <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    cmd.clearAcc   = startReq;
    cmd.accumulate = runQ;
    cmd.snapLow    = regRdEn && (regAddr == ADDR_HIGH);
  end

  assign ctrlWord  = {selQ, 8'h00, durQ, 6'b0, doneQ, runQ};
  assign activeSel = selQ;
  assign running   = runQ;
  assign done      = doneQ;
endmodule

// File: rtl/lwm_datapath.sv
module lwm_datapath
  import lwm_pkg::*;
#(
  parameter int CHUNK_W = 4,
  parameter int RESULT_W = 64
) (
  input  logic                clk,
  input  logic                rstN,
  input  lwmCmd_t             cmd,
  input  logic [7:0]          sel,
  input  logic [7:0]          linkState,
  input  logic [CHUNK_W-1:0]  txChunks,
  input  logic [CHUNK_W-1:0]  rxChunks,
  output logic [RESULT_W-1:0] result,
  output logic [31:0]         lowSnap
);
  logic [RESULT_W-1:0] accQ, inc;
  logic [31:0]         snapQ;
  logic                hit;

  always_comb begin
    hit = 1'b0;
    case (sel)
      8'h00: hit = 1'b1;
      8'h01: hit = linkState[ST_TXL0S];
      8'h02: hit = linkState[ST_RXL0S];
      8'h03: hit = linkState[ST_L0];
      8'h04: hit = linkState[ST_L1];
      8'h05: hit = linkState[ST_L11];
      8'h06: hit = linkState[ST_L12];
      8'h07: hit = linkState[ST_CFG];
      8'h08: hit = linkState[ST_TXL0S] && linkState[ST_RXL0S];
      8'h09: hit = linkState[ST_AUX];
      default: hit = 1'b0;
    endcase
    case (sel)
      8'h20:   inc = RESULT_W'(txChunks);
      8'h21:   inc = RESULT_W'(rxChunks);
      default: inc = RESULT_W'(hit);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accQ  <= '0;
      snapQ <= '0;
    end else begin
      if (cmd.clearAcc)        accQ <= '0;
      else if (cmd.accumulate) accQ <= accQ + inc;
      if (cmd.snapLow)         snapQ <= accQ[31:0];
    end
  end

  assign result  = accQ;
  assign lowSnap = snapQ;
endmodule

// File: rtl/link_window_meter.sv
module link_window_meter
  import lwm_pkg::*;
#(
  parameter int CYCLES_PER_US = 125,
  parameter int CHUNK_W = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [7:0]         regAddr,
  input  logic [31:0]        regWrData,
  output logic [31:0]        regRdData,
  input  logic [7:0]         linkState,
  input  logic [CHUNK_W-1:0] txChunks,
  input  logic [CHUNK_W-1:0] rxChunks
);
  localparam int RESULT_W = 64;
  localparam int TIMER_W  = 40;

  lwmCmd_t             cmd;
  logic [31:0]         ctrlWord, lowSnap;
  logic [7:0]          activeSel;
  logic                running, done;
  logic [RESULT_W-1:0] result;

  lwm_ctrl #(.CYCLES_PER_US(CYCLES_PER_US), .TIMER_W(TIMER_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .cmd(cmd),
    .ctrlWord(ctrlWord), .activeSel(activeSel), .running(running), .done(done)
  );

  lwm_datapath #(.CHUNK_W(CHUNK_W), .RESULT_W(RESULT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cmd(cmd), .sel(activeSel),
    .linkState(linkState), .txChunks(txChunks), .rxChunks(rxChunks),
    .result(result), .lowSnap(lowSnap)
  );

  always_comb begin
    case (regAddr)
      ADDR_CTRL: regRdData = ctrlWord;
      ADDR_LOW:  regRdData = lowSnap;
      ADDR_HIGH: regRdData = result[63:32];
      default:   regRdData = 32'h0;
    endcase
  end
endmodule

// File: rtl/lwm_checker.sv
module lwm_checker (
  input logic        clk,
  input logic        rstN,
  input logic        running,
  input logic        done,
  input logic        clearAcc,
  input logic        accumulate,
  input logic [63:0] result,
  input logic [7:0]  sel,
  input logic        regRdEn,
  input logic [7:0]  regAddr,
  input logic [31:0] regRdData
);
  a_r4_done_stops: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> !running);

  a_r5_start_clears: assert property (@(posedge clk) disable iff (!rstN)
    $past(clearAcc) |-> (result == 64'd0));

  a_r8_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    (!$past(accumulate) && !$past(clearAcc)) |-> $stable(result));

  a_r9_cfg_frozen: assert property (@(posedge clk) disable iff (!rstN)
    (running && $past(running)) |-> $stable(sel));

  a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (regRdEn && regAddr != 8'h10 && regAddr != 8'h14 && regAddr != 8'h18)
      |-> (regRdData == 32'h0));
endmodule

bind link_window_meter lwm_checker u_lwm_checker (
  .clk(clk), .rstN(rstN), .running(running), .done(done),
  .clearAcc(cmd.clearAcc), .accumulate(cmd.accumulate), .result(result),
  .sel(activeSel), .regRdEn(regRdEn), .regAddr(regAddr), .regRdData(regRdData)
);

// File: tb/test_link_window_meter.sv
module test_link_window_meter;
  localparam int CPU = 2;
  localparam int CW  = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          regWrEn = 1'b0, regRdEn = 1'b0;
  logic [7:0]    regAddr = 8'h0;
  logic [31:0]   regWrData = 32'h0;
  logic [31:0]   regRdData;
  logic [7:0]    linkState = 8'h0;
  logic [CW-1:0] txChunks = '0, rxChunks = '0;

  int checks = 0, errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  link_window_meter #(.CYCLES_PER_US(CPU), .CHUNK_W(CW)) i_link_window_meter (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .linkState(linkState), .txChunks(txChunks), .rxChunks(rxChunks)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regAddr = 8'h0; regWrData = 32'h0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    #1 d = regRdData;
    @(negedge clk);
    regRdEn = 1'b0; regAddr = 8'h0;
  endtask

  task automatic rd64(output logic [63:0] v);
    logic [31:0] h, l;
    rd(8'h18, h);
    rd(8'h14, l);
    v = {h, l};
  endtask

  task automatic test_reset();
    logic [31:0] d;
    rd(8'h10, d); check("R1 ctrl", d, 0);
    rd(8'h18, d); check("R1 high", d, 0);
    rd(8'h14, d); check("R1 low", d, 0);
    rd(8'h24, d); check("R2 unmapped", d, 0);
  endtask

  task automatic timed_run(input logic [7:0] sel, input logic [7:0] dur,
                           input int waitCycles, output logic [63:0] v);
    wr(8'h10, {sel, 8'h00, dur, 8'h01});
    repeat (waitCycles) @(negedge clk);
    rd64(v);
  endtask

  task automatic test_short_window();
    logic [63:0] v; logic [31:0] c;
    timed_run(8'h00, 8'hFF, 20, v);
    check("R3 4us window length", v, 4 * CPU);
    rd(8'h10, c); check("R4 done set, enable cleared", c, 32'h0000FF02);
    repeat (10) @(negedge clk);
    rd64(v); check("R4 frozen after window", v, 4 * CPU);
    wr(8'h10, 32'h0000FF01);
    rd(8'h10, c); check("R4 new start clears done", c, 32'h0000FF01);
    repeat (12) @(negedge clk);
  endtask

  task automatic test_states();
    logic [63:0] v;
    linkState = 8'h20;
    timed_run(8'h06, 8'hFF, 20, v); check("R6 L1.2 counted", v, 4 * CPU);
    timed_run(8'h03, 8'hFF, 20, v); check("R6 L0 not counted", v, 0);
    linkState = 8'h06;
    timed_run(8'h08, 8'hFF, 20, v); check("R6 both L0s", v, 4 * CPU);
    timed_run(8'h01, 8'hFF, 20, v); check("R6 TX L0s", v, 4 * CPU);
    linkState = 8'h02;
    timed_run(8'h08, 8'hFF, 20, v); check("R6 both L0s needs RX", v, 0);
    linkState = 8'h80;
    timed_run(8'h09, 8'hFF, 20, v); check("R6 L1 aux", v, 4 * CPU);
    linkState = 8'h00;
  endtask

  task automatic test_payload();
    logic [63:0] v;
    txChunks = 4'd3; rxChunks = 4'd5;
    timed_run(8'h20, 8'hFF, 20, v); check("R7 tx payload", v, 3 * 4 * CPU);
    timed_run(8'h21, 8'hFF, 20, v); check("R7 rx payload", v, 5 * 4 * CPU);
    txChunks = '0; rxChunks = '0;
  endtask

  task automatic test_long_window();
    logic [63:0] v; logic [31:0] c;
    wr(8'h10, 32'h00000101);
    repeat (900) @(negedge clk);
    rd(8'h10, c); check("R3 1ms still running", c, 32'h00000101);
    repeat (1200) @(negedge clk);
    rd64(v); check("R3 1ms window length", v, 1000 * CPU);
    rd(8'h10, c); check("R4 1ms done", c, 32'h00000102);
  endtask

  task automatic test_manual();
    logic [63:0] v, v2;
    wr(8'h10, 32'h00000001);
    repeat (10) @(negedge clk);
    wr(8'h10, 32'h00000000);
    rd64(v); check("R8 manual count", v, 12);
    repeat (10) @(negedge clk);
    rd64(v2); check("R8 manual hold", v2, 12);
  endtask

  task automatic test_unlisted_duration();
    logic [63:0] v; logic [31:0] c;
    wr(8'h10, 32'h00000701);
    repeat (30) @(negedge clk);
    rd(8'h10, c); check("R8 unlisted code runs on", c, 32'h00000701);
    wr(8'h10, 32'h00000700);
    rd64(v); check("R8 unlisted code count", v, 34);
  endtask

  task automatic test_reconfig_ignored();
    logic [63:0] v; logic [31:0] c;
    linkState = 8'h00;
    wr(8'h10, 32'h00000001);
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h0300FF01);
    repeat (4) @(negedge clk);
    wr(8'h10, 32'h0300FF00);
    rd(8'h10, c); check("R9 fields unchanged", c, 32'h00000000);
    rd64(v); check("R9 select kept during run", v, 12);
  endtask

  task automatic test_abort();
    logic [63:0] v; logic [31:0] c;
    wr(8'h10, 32'h00000101);
    repeat (3) @(negedge clk);
    wr(8'h10, 32'h00000100);
    rd(8'h10, c); check("R11 abort no done", c, 32'h00000100);
    rd64(v); check("R11 abort holds count", v, 5);
  endtask

  task automatic test_snapshot();
    logic [31:0] h, l;
    wr(8'h10, 32'h00000001);
    rd(8'h18, h); check("R10 high word", h, 0);
    repeat (5) @(negedge clk);
    rd(8'h14, l); check("R10 low from snapshot", l, 1);
    wr(8'h10, 32'h00000000);
    rd(8'h14, l); check("R10 snapshot until next high read", l, 1);
    rd(8'h18, h);
    rd(8'h14, l); check("R5 R10 fresh snapshot", l, 11);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    test_reset();
    test_short_window();
    test_states();
    test_payload();
    test_long_window();
    test_manual();
    test_unlisted_duration();
    test_reconfig_ignored();
    test_abort();
    test_snapshot();
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule